// File: doc/BRIEF.md
# IO bank freeze and thaw sequencer

This block steps the pad controls of one high-speed IO bank between a frozen state and a thawed state. When the bank is frozen, its pads are held in a safe condition: outputs are tristated, the weak pull-up and the bus-hold keepers are engaged, slew control is forced, configuration-done is low, and the regulator, termination and DLL resets are held. Thawing releases these controls one group at a time in a fixed order. Some waits between groups are short minimums, counted in system clocks and derived from the clock frequency. The two longest waits are counted in rising edges of a free-running internal oscillator. That oscillator is asynchronous to the system clock, so it is synchronized first.

A single-cycle pulse on `freeze_req` or `thaw_req` starts a sequence. A request that arrives while the opposite sequence is running is held, and it runs after that sequence ends. A request for the state the bank already has is dropped. The block carries no data stream, so every pin is a plain level-sensitive control or status line with no valid/ready handshake. Every control output comes straight from a flop, so no output glitches.

Top module: `iobank_freeze_seq`

## Requirements
- R1: After reset, the outputs are in the frozen state: pad_slew_n=0, pad_wkpu_n=0, pad_tri_n=0, pad_hold_n=0, cfg_done=0, vreg_rst=1, term_rst=1, dll_rst=1, term_cal_en=0 and bank_frozen=1.
- R2: A freeze request seen at a clock edge while the bank is thawed and idle changes the outputs in three updates on that edge and the two edges after it. The first update drives pad_slew_n, pad_wkpu_n and pad_tri_n low. The second drives pad_hold_n and cfg_done low and vreg_rst and term_rst high. The third drives dll_rst high and term_cal_en low and sets bank_frozen to 1.
- R3: A thaw request seen at a clock edge while the bank is frozen and idle clears dll_rst on that edge. term_cal_en rises exactly GAP clocks later, where GAP = ceil(MIN_GAP_NS*CLK_MHZ/1000), with a minimum of 1.
- R4: After term_cal_en rises, CAL_OSC_CYCLES synchronized rising edges of osc_tick are counted. Then pad_hold_n and cfg_done rise and term_rst falls, all on the same clock edge.
- R5: After R4, SETTLE_OSC_CYCLES synchronized rising edges of osc_tick are counted. Then pad_wkpu_n and pad_tri_n rise together.
- R6: vreg_rst falls GAP clocks after the R5 step. GAP clocks after that, pad_slew_n rises and bank_frozen falls on the same edge, which ends the thaw.
- R7: A freeze request during a thaw does not alter the thaw. The freeze sequence then starts on the clock edge after the final thaw update.
- R8: A thaw request during a freeze does not alter the freeze. The thaw sequence then starts on the clock edge after the final freeze update.
- R9: When the block is idle, a freeze request while frozen and a thaw request while thawed leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freeze_req | input | 1 | Pulse: request the frozen state |
| thaw_req | input | 1 | Pulse: request the thawed state |
| osc_tick | input | 1 | Internal oscillator, asynchronous to clk |
| pad_slew_n | output | 1 | Slew control, active low |
| pad_wkpu_n | output | 1 | Weak pull-up enable, active low |
| pad_tri_n | output | 1 | Output tristate, active low |
| pad_hold_n | output | 1 | Bus-hold keeper, active low |
| cfg_done | output | 1 | Pad configuration done, active high |
| vreg_rst | output | 1 | Regulator reset, active high |
| term_rst | output | 1 | Termination reset, active high |
| dll_rst | output | 1 | DLL reset, active high |
| term_cal_en | output | 1 | Termination calibration enable, active high |
| bank_frozen | output | 1 | Status: 1 frozen, 0 thawed |

## Verification
Each full thaw and freeze is run at four oscillator periods, from just over three system clocks to about twelve. Across these runs the clock-counted gaps stay fixed, while the clock length of the two oscillator waits scales with the period. The oscillator edges counted inside those waits stay at the configured count. This separates correct edge counting from counting clocks, from counting both edges, and from off-by-one loads. Each step's output vector is compared in order, so any swap or merge of steps shows up. Opposite requests injected part-way through each sequence, and redundant requests at idle, show that pending requests are held or dropped as required.

// File: rtl/iobank_frz_pkg.sv
package iobank_frz_pkg;

  typedef struct packed {
    logic slew_n;
    logic wkpu_n;
    logic tri_n;
    logic hold_n;
    logic cfg_done;
    logic vreg_rst;
    logic term_rst;
    logic dll_rst;
    logic cal_en;
  } pad_ctl_t;

  localparam pad_ctl_t CTL_FROZEN = '{slew_n: 1'b0, wkpu_n: 1'b0, tri_n: 1'b0,
                                      hold_n: 1'b0, cfg_done: 1'b0, vreg_rst: 1'b1,
                                      term_rst: 1'b1, dll_rst: 1'b1, cal_en: 1'b0};
  localparam pad_ctl_t CTL_THAWED = '{slew_n: 1'b1, wkpu_n: 1'b1, tri_n: 1'b1,
                                      hold_n: 1'b1, cfg_done: 1'b1, vreg_rst: 1'b0,
                                      term_rst: 1'b0, dll_rst: 1'b0, cal_en: 1'b1};

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FRZ_PADS,
    ST_FRZ_HOLD,
    ST_THW_DLL,
    ST_THW_CAL,
    ST_THW_HOLD,
    ST_THW_PADS,
    ST_THW_VREG
  } seq_state_t;

  function automatic int ns_to_cycles(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/osc_edge_sync.sv
module osc_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_async,
  output logic osc_rise
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[CHAIN-2:0], osc_async};
  end

  // rising edge seen between the last synchronizer flop and the history flop
  assign osc_rise = chain_q[CHAIN-2] & ~chain_q[CHAIN-1];

endmodule

// File: rtl/seq_wait_timer.sv
module seq_wait_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          load_osc,
  input  logic          osc_rise,
  output logic          done
);
  logic [TW-1:0] cnt_q;
  logic          osc_mode_q;
  logic          step;

  assign step = osc_mode_q ? osc_rise : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      osc_mode_q <= 1'b0;
    end else if (load) begin
      cnt_q      <= load_val;
      osc_mode_q <= load_osc;
    end else if (cnt_q != '0 && step) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

  // R4: an oscillator wait only advances on a synchronized oscillator edge
  p_osc_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_mode_q && !osc_rise && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/freeze_seq_fsm.sv
module freeze_seq_fsm
  import iobank_frz_pkg::*;
#(
  parameter int TW         = 8,
  parameter int GAP        = 5,
  parameter int CAL_OSC    = 1000,
  parameter int SETTLE_OSC = 33
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          freeze_req,
  input  logic          thaw_req,
  input  logic          tmr_done,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          tmr_osc,
  output pad_ctl_t      ctl,
  output logic          frozen
);
  localparam logic [TW-1:0] LD_GAP    = TW'(GAP - 1);
  localparam logic [TW-1:0] LD_CAL    = TW'(CAL_OSC);
  localparam logic [TW-1:0] LD_SETTLE = TW'(SETTLE_OSC);

  seq_state_t state_q;
  logic       pend_frz_q, pend_thw_q;
  logic       start_frz, start_thw;

  assign start_frz = (state_q == ST_IDLE) && (freeze_req || pend_frz_q) && !frozen;
  assign start_thw = (state_q == ST_IDLE) && !start_frz && (thaw_req || pend_thw_q) && frozen;

  // timer is loaded on the same edge that applies a thaw step
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = LD_GAP;
    tmr_osc  = 1'b0;
    if (start_thw) begin
      tmr_load = 1'b1;
    end else if (tmr_done) begin
      unique case (state_q)
        ST_THW_DLL:  begin tmr_load = 1'b1; tmr_val = LD_CAL;    tmr_osc = 1'b1; end
        ST_THW_CAL:  begin tmr_load = 1'b1; tmr_val = LD_SETTLE; tmr_osc = 1'b1; end
        ST_THW_HOLD: tmr_load = 1'b1;
        ST_THW_PADS: tmr_load = 1'b1;
        default:     tmr_load = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      ctl        <= CTL_FROZEN;
      frozen     <= 1'b1;
      pend_frz_q <= 1'b0;
      pend_thw_q <= 1'b0;
    end else begin
      if (state_q == ST_IDLE) begin
        pend_frz_q <= 1'b0;
        pend_thw_q <= 1'b0;
      end else begin
        pend_frz_q <= pend_frz_q | freeze_req;
        pend_thw_q <= pend_thw_q | thaw_req;
      end
      unique case (state_q)
        ST_IDLE: begin
          if (start_frz) begin
            ctl.slew_n <= 1'b0;
            ctl.wkpu_n <= 1'b0;
            ctl.tri_n  <= 1'b0;
            state_q    <= ST_FRZ_PADS;
          end else if (start_thw) begin
            ctl.dll_rst <= 1'b0;
            state_q     <= ST_THW_DLL;
          end
        end
        ST_FRZ_PADS: begin
          ctl.hold_n   <= 1'b0;
          ctl.cfg_done <= 1'b0;
          ctl.vreg_rst <= 1'b1;
          ctl.term_rst <= 1'b1;
          state_q      <= ST_FRZ_HOLD;
        end
        ST_FRZ_HOLD: begin
          ctl.dll_rst <= 1'b1;
          ctl.cal_en  <= 1'b0;
          frozen      <= 1'b1;
          state_q     <= ST_IDLE;
        end
        ST_THW_DLL: if (tmr_done) begin
          ctl.cal_en <= 1'b1;
          state_q    <= ST_THW_CAL;
        end
        ST_THW_CAL: if (tmr_done) begin
          ctl.hold_n   <= 1'b1;
          ctl.cfg_done <= 1'b1;
          ctl.term_rst <= 1'b0;
          state_q      <= ST_THW_HOLD;
        end
        ST_THW_HOLD: if (tmr_done) begin
          ctl.wkpu_n <= 1'b1;
          ctl.tri_n  <= 1'b1;
          state_q    <= ST_THW_PADS;
        end
        ST_THW_PADS: if (tmr_done) begin
          ctl.vreg_rst <= 1'b0;
          state_q      <= ST_THW_VREG;
        end
        ST_THW_VREG: if (tmr_done) begin
          ctl.slew_n <= 1'b1;
          frozen     <= 1'b0;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3: calibration is enabled only once the DLL reset has been released
  p_cal_after_dll_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl.cal_en) |-> !ctl.dll_rst);

  // R4: termination reset clears together with bus-hold release and config-done
  p_term_with_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl.term_rst) |-> (ctl.hold_n && ctl.cfg_done));

  // R5: pads leave tristate only after the hold step
  p_pads_after_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl.tri_n) |-> (ctl.hold_n && ctl.cal_en && !ctl.term_rst));

  // R6: regulator reset clears only after the pads are released
  p_vreg_after_pads_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl.vreg_rst) |-> (ctl.wkpu_n && ctl.tri_n));

  // R6: the thawed flag appears only with every control thawed
  p_thaw_flag_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frozen) |-> (ctl == CTL_THAWED));

  // R2: the frozen flag appears only with every control frozen
  p_freeze_flag_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frozen) |-> (ctl == CTL_FROZEN));

endmodule

// File: rtl/iobank_freeze_seq.sv
module iobank_freeze_seq
  import iobank_frz_pkg::*;
#(
  parameter int CLK_MHZ           = 125,
  parameter int MIN_GAP_NS        = 40,
  parameter int CAL_OSC_CYCLES    = 1000,
  parameter int SETTLE_OSC_CYCLES = 33,
  parameter int SYNC_STAGES       = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic freeze_req,
  input  logic thaw_req,
  input  logic osc_tick,
  output logic pad_slew_n,
  output logic pad_wkpu_n,
  output logic pad_tri_n,
  output logic pad_hold_n,
  output logic cfg_done,
  output logic vreg_rst,
  output logic term_rst,
  output logic dll_rst,
  output logic term_cal_en,
  output logic bank_frozen
);
  localparam int GAP = ns_to_cycles(MIN_GAP_NS, CLK_MHZ);
  localparam int TW  = $clog2(max3(GAP, CAL_OSC_CYCLES, SETTLE_OSC_CYCLES) + 1);

  logic          osc_rise;
  logic          tmr_load, tmr_osc, tmr_done;
  logic [TW-1:0] tmr_val;
  pad_ctl_t      ctl;

  osc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_async(osc_tick),
    .osc_rise (osc_rise)
  );

  seq_wait_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .load_osc(tmr_osc),
    .osc_rise(osc_rise),
    .done    (tmr_done)
  );

  freeze_seq_fsm #(
    .TW        (TW),
    .GAP       (GAP),
    .CAL_OSC   (CAL_OSC_CYCLES),
    .SETTLE_OSC(SETTLE_OSC_CYCLES)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .freeze_req(freeze_req),
    .thaw_req  (thaw_req),
    .tmr_done  (tmr_done),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .tmr_osc   (tmr_osc),
    .ctl       (ctl),
    .frozen    (bank_frozen)
  );

  assign pad_slew_n  = ctl.slew_n;
  assign pad_wkpu_n  = ctl.wkpu_n;
  assign pad_tri_n   = ctl.tri_n;
  assign pad_hold_n  = ctl.hold_n;
  assign cfg_done    = ctl.cfg_done;
  assign vreg_rst    = ctl.vreg_rst;
  assign term_rst    = ctl.term_rst;
  assign dll_rst     = ctl.dll_rst;
  assign term_cal_en = ctl.cal_en;

endmodule

// File: tb/iobank_freeze_seq_test.sv
`timescale 1ns/1ps
module iobank_freeze_seq_test;
  localparam int CLK_MHZ = 125;
  localparam int MIN_NS  = 40;
  localparam int CAL     = 20;
  localparam int SETTLE  = 7;
  localparam int GAP     = ((MIN_NS * CLK_MHZ + 999) / 1000 < 1) ? 1 : (MIN_NS * CLK_MHZ + 999) / 1000;
  // bit positions of the observed vector
  localparam int B_FRZ = 9, B_SLEW = 8, B_WKPU = 7, B_TRI = 6, B_HOLD = 5,
                 B_CFG = 4, B_VREG = 3, B_TERM = 2, B_DLL = 1, B_CAL = 0;
  localparam logic [9:0] V_FROZEN = 10'b1000001110;
  localparam logic [9:0] V_THAWED = 10'b0111110001;

  logic clk = 1'b0, rst_n = 1'b0, freeze_req = 1'b0, thaw_req = 1'b0, osc_tick = 1'b0;
  logic pad_slew_n, pad_wkpu_n, pad_tri_n, pad_hold_n, cfg_done;
  logic vreg_rst, term_rst, dll_rst, term_cal_en, bank_frozen;
  logic [9:0] obs;
  logic [9:0] tv [0:6];
  logic [9:0] fv [0:3];
  int checks = 0, errors = 0, cyc = 0, osc_cnt = 0, osc_half = 13;
  bit done_flag = 0;

  iobank_freeze_seq #(.CLK_MHZ(CLK_MHZ), .MIN_GAP_NS(MIN_NS),
    .CAL_OSC_CYCLES(CAL), .SETTLE_OSC_CYCLES(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .freeze_req(freeze_req), .thaw_req(thaw_req),
    .osc_tick(osc_tick), .pad_slew_n(pad_slew_n), .pad_wkpu_n(pad_wkpu_n),
    .pad_tri_n(pad_tri_n), .pad_hold_n(pad_hold_n), .cfg_done(cfg_done),
    .vreg_rst(vreg_rst), .term_rst(term_rst), .dll_rst(dll_rst),
    .term_cal_en(term_cal_en), .bank_frozen(bank_frozen));

  assign obs = {bank_frozen, pad_slew_n, pad_wkpu_n, pad_tri_n, pad_hold_n,
                cfg_done, vreg_rst, term_rst, dll_rst, term_cal_en};

  always #4 clk = ~clk;
  initial forever #(osc_half) osc_tick = ~osc_tick;
  always @(posedge osc_tick) osc_cnt++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done_flag) begin
      errors++;
      $display("FAIL watchdog: actual cycles %0d expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // waits for the next change of the outputs; returns negedges waited and osc edges seen
  task automatic wait_change(output int n, output int oe);
    logic [9:0] prev;
    int o0;
    prev = obs; o0 = osc_cnt; n = 0;
    do begin
      @(negedge clk);
      freeze_req = 1'b0; thaw_req = 1'b0;
      n++;
    end while (obs == prev && n < 5000);
    oe = osc_cnt - o0;
  endtask

  task automatic do_thaw(input bit pulse, input bit mid_freeze);
    int n, oe;
    if (pulse) thaw_req = 1'b1;
    wait_change(n, oe);
    chk(n == 1, "R3 thaw start latency", n, 1);
    chk(obs == tv[1], "R3 dll release step", obs, tv[1]);
    wait_change(n, oe);
    chk(obs == tv[2], "R3 cal enable step", obs, tv[2]);
    chk(n == GAP, "R3 dll to cal gap", n, GAP);
    if (mid_freeze) freeze_req = 1'b1;
    wait_change(n, oe);
    chk(obs == tv[3], "R4 hold release step", obs, tv[3]);
    chk(oe >= CAL - 1 && oe <= CAL + 1, "R4 cal wait osc edges", oe, CAL);
    wait_change(n, oe);
    chk(obs == tv[4], "R5 pad release step", obs, tv[4]);
    chk(oe >= SETTLE - 1 && oe <= SETTLE + 1, "R5 settle wait osc edges", oe, SETTLE);
    wait_change(n, oe);
    chk(obs == tv[5], "R6 vreg release step", obs, tv[5]);
    chk(n == GAP, "R6 pads to vreg gap", n, GAP);
    wait_change(n, oe);
    chk(obs == tv[6], "R6 slew and flag step", obs, tv[6]);
    chk(n == GAP, "R6 vreg to slew gap", n, GAP);
  endtask

  task automatic do_freeze(input bit pulse, input bit mid_thaw);
    int n, oe;
    if (pulse) freeze_req = 1'b1;
    wait_change(n, oe);
    chk(n == 1, "R2 freeze start latency", n, 1);
    chk(obs == fv[1], "R2 freeze pads step", obs, fv[1]);
    if (mid_thaw) thaw_req = 1'b1;
    wait_change(n, oe);
    chk(n == 1 && obs == fv[2], "R2 freeze hold step", obs, fv[2]);
    wait_change(n, oe);
    chk(n == 1 && obs == fv[3], "R2 freeze dll step", obs, fv[3]);
  endtask

  task automatic idle_redundant(input bit frz, input string req);
    logic [9:0] prev;
    bit same;
    prev = obs; same = 1;
    if (frz) freeze_req = 1'b1; else thaw_req = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      freeze_req = 1'b0; thaw_req = 1'b0;
      if (obs != prev) same = 0;
    end
    chk(same, req, obs, prev);
  endtask

  initial begin
    tv[0] = V_FROZEN;
    tv[1] = tv[0]; tv[1][B_DLL] = 1'b0;
    tv[2] = tv[1]; tv[2][B_CAL] = 1'b1;
    tv[3] = tv[2]; tv[3][B_HOLD] = 1'b1; tv[3][B_CFG] = 1'b1; tv[3][B_TERM] = 1'b0;
    tv[4] = tv[3]; tv[4][B_WKPU] = 1'b1; tv[4][B_TRI] = 1'b1;
    tv[5] = tv[4]; tv[5][B_VREG] = 1'b0;
    tv[6] = tv[5]; tv[6][B_SLEW] = 1'b1; tv[6][B_FRZ] = 1'b0;
    fv[0] = V_THAWED;
    fv[1] = fv[0]; fv[1][B_SLEW] = 1'b0; fv[1][B_WKPU] = 1'b0; fv[1][B_TRI] = 1'b0;
    fv[2] = fv[1]; fv[2][B_HOLD] = 1'b0; fv[2][B_CFG] = 1'b0;
    fv[2][B_VREG] = 1'b1; fv[2][B_TERM] = 1'b1;
    fv[3] = fv[2]; fv[3][B_DLL] = 1'b1; fv[3][B_CAL] = 1'b0; fv[3][B_FRZ] = 1'b1;

    repeat (3) @(negedge clk);
    chk(obs == V_FROZEN, "R1 state during reset", obs, V_FROZEN);
    rst_n = 1'b1;
    @(negedge clk);
    chk(obs == V_FROZEN, "R1 state after reset", obs, V_FROZEN);
    chk(tv[6] == V_THAWED && fv[3] == V_FROZEN, "R6 bench vector end states", tv[6], V_THAWED);
    idle_redundant(1'b1, "R9 freeze while frozen ignored");

    for (int k = 0; k < 4; k++) begin
      osc_half = (k == 0) ? 13 : (k == 1) ? 19 : (k == 2) ? 31 : 47;
      repeat (5) @(negedge clk);
      do_thaw(1'b1, 1'b0);
      idle_redundant(1'b0, "R9 thaw while thawed ignored");
      do_freeze(1'b1, 1'b0);
      idle_redundant(1'b1, "R9 freeze while frozen ignored");
    end

    osc_half = 23;
    repeat (5) @(negedge clk);
    do_thaw(1'b1, 1'b1);   // R7: freeze held until thaw completes
    do_freeze(1'b0, 1'b0); // R7: runs on the edge after the thaw's final step
    chk(obs == V_FROZEN, "R7 frozen after pending freeze", obs, V_FROZEN);
    repeat (3) @(negedge clk);
    do_thaw(1'b1, 1'b0);
    do_freeze(1'b1, 1'b1); // R8: thaw held until freeze completes
    do_thaw(1'b0, 1'b0);   // R8: runs on the edge after the freeze's final step
    chk(obs == V_THAWED, "R8 thawed after pending thaw", obs, V_THAWED);

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule